// File: doc/BRIEF.md
# Quadrature Encoder Position Tracker with Backlash Filter

This block follows a mechanical quadrature encoder and keeps a signed position count at single-quadrant resolution. Both phase inputs are brought into the clock domain through a register chain. Each new sampled phase pair is then compared with the pair sampled one clock earlier. A change in exactly one phase moves the count by one, so every line of the encoder gives four counts. A change in both phases cannot be resolved to a direction. It is reported on a sticky flag and never moves the count, so contact bounce on one phase at a time can never build up a position error.

An optional backlash filter can be placed on the output for hand-operated controls. When it is on, the reported position may sit one count above the internal count. A reversal of direction then has to travel one extra quadrant before the output moves, which hides the one-count flicker that bounce produces. The internal count always follows every step, so the filter causes at most one count of offset and never an accumulated error.

The filter is a two-state machine. In `BL_LOW` the output equals the internal count. In `BL_HIGH` the output is one above it. The transitions are:
- `BL_LOW` to `BL_HIGH` on a down step.
- `BL_HIGH` to `BL_LOW` on an up step.
- Back to `BL_LOW` whenever the filter is disabled or a synchronous reset is applied.

The step decoder classifies each sample as one of four outcomes: `STEP_NONE`, `STEP_UP`, `STEP_DOWN` or `STEP_BAD`.

Top module: `qdec_tracker`

## Requirements
- R1: With the default two synchroniser stages, a phase change presented before a rising edge is reflected in `position` and the step strobe right after the third rising edge. After the second rising edge nothing has changed yet.
- R2: Take the phase pair as {A,B}. Moving forward through 00, 10, 11, 01 and back to 00 adds one per change. Moving through that order backward subtracts one per change. One full cycle gives four counts.
- R3: A sample in which both phases differ from the previous sample leaves the count unchanged. It produces no step strobe and sets `illegal_flag`.
- R4: `illegal_flag` stays set until `flag_clr` or `srst` is applied. If a new illegal change and `flag_clr` fall in the same cycle, the flag stays set.
- R5: Bounce on one phase gives up and down steps on adjacent clocks. All of these steps are applied, so the net position equals the final phase state and `illegal_flag` stays clear.
- R6: `step_valid` pulses high for exactly one cycle together with each count update. `step_dir` is 1 for up and 0 for down.
- R7: With `hyst_en` = 1, `position` always equals the internal count or the internal count plus one. A reversal of direction changes `position` only after one extra quadrant of travel.
- R8: With `hyst_en` = 0, `position` equals the internal count from the next clock onward. Clearing `hyst_en` while the output is held high drops it to the internal count.
- R9: `srst` zeroes the count, clears `illegal_flag` and returns the filter to `BL_LOW`. It leaves the synchroniser and the previous-sample history alone, so a steady nonzero phase state after `srst` causes no step and no flag.
- R10: `arst` asynchronously clears the count, the flag, the strobes, the filter and all phase history to 00.
- R11: The count wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| srst | input | 1 | Synchronous count reset, active high |
| hyst_en | input | 1 | Enables the one-quadrant backlash filter |
| flag_clr | input | 1 | Clears the sticky illegal flag |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| position | output | CNT_W | Reported position, two's complement |
| illegal_flag | output | 1 | Sticky flag raised by a two-phase change |
| step_valid | output | 1 | One-cycle strobe for each counted step |
| step_dir | output | 1 | Direction of the strobed step, 1 = up |

## Verification
The bench builds the tracker with CNT_W = 4 and two synchroniser stages. With a 4-bit count, the wrap from 15 to 0 and from 0 to 15 is reached in sixteen quadrant steps. Keeping the default synchroniser depth keeps the three-edge latency of R1 exact for every directed stimulus. The narrow count also lets back-to-back bounce, illegal changes, the flag set-versus-clear race and the backlash states be checked against short, hand-computed sequences.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;

    typedef enum logic {
        BL_LOW  = 1'b0,
        BL_HIGH = 1'b1
    } bl_state_t;

    // Map the {A,B} pair to its place in the forward cycle 00,10,11,01.
    function automatic logic [1:0] quad_index(input logic [1:0] ab);
        quad_index = {ab[0], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[g] <= '0;
                    else      chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[g] <= '0;
                    else      chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
    import qdec_pkg::*;
(
    input  logic        clk,
    input  logic        arst,
    input  logic [1:0]  cur_ab,
    output logic [1:0]  prev_ab,
    output step_t       step
);

    logic [1:0] prev_q;
    logic [1:0] delta;

    // History is kept across synchronous reset on purpose.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) prev_q <= 2'b00;
        else      prev_q <= cur_ab;
    end

    always_comb begin
        delta = quad_index(cur_ab) - quad_index(prev_q);
        unique case (delta)
            2'd0: step = STEP_NONE;
            2'd1: step = STEP_UP;
            2'd2: step = STEP_BAD;
            2'd3: step = STEP_DOWN;
            default: step = STEP_NONE;
        endcase
    end

    assign prev_ab = prev_q;

endmodule

// File: rtl/qdec_backlash.sv
module qdec_backlash
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  arst,
    input  logic  srst,
    input  logic  hyst_en,
    input  step_t step,
    output logic  hold_high
);

    bl_state_t state_q;
    bl_state_t state_d;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= BL_LOW;
        else      state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (srst || !hyst_en) begin
            state_d = BL_LOW;
        end else begin
            unique case (state_q)
                BL_LOW:  if (step == STEP_DOWN) state_d = BL_HIGH;
                BL_HIGH: if (step == STEP_UP)   state_d = BL_LOW;
                default: state_d = BL_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            BL_HIGH: hold_high = 1'b1;
            default: hold_high = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdec_tracker.sv
module qdec_tracker
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             srst,
    input  logic             hyst_en,
    input  logic             flag_clr,
    input  logic             phase_a,
    input  logic             phase_b,
    output logic [CNT_W-1:0] position,
    output logic             illegal_flag,
    output logic             step_valid,
    output logic             step_dir
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [1:0]       smp_ab;
    logic [1:0]       prev_ab;
    step_t            step;
    logic             hold_high;
    logic [CNT_W-1:0] raw_q;
    logic             flag_q;
    logic             sv_q;
    logic             sd_q;

    qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .arst (arst),
        .din  ({phase_a, phase_b}),
        .dout (smp_ab)
    );

    qdec_step_decode u_dec (
        .clk     (clk),
        .arst    (arst),
        .cur_ab  (smp_ab),
        .prev_ab (prev_ab),
        .step    (step)
    );

    qdec_backlash u_bl (
        .clk       (clk),
        .arst      (arst),
        .srst      (srst),
        .hyst_en   (hyst_en),
        .step      (step),
        .hold_high (hold_high)
    );

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            raw_q  <= '0;
            flag_q <= 1'b0;
            sv_q   <= 1'b0;
            sd_q   <= 1'b0;
        end else if (srst) begin
            raw_q  <= '0;
            flag_q <= 1'b0;
            sv_q   <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            sv_q <= 1'b0;
            unique case (step)
                STEP_UP: begin
                    raw_q <= raw_q + ONE;
                    sv_q  <= 1'b1;
                    sd_q  <= 1'b1;
                end
                STEP_DOWN: begin
                    raw_q <= raw_q - ONE;
                    sv_q  <= 1'b1;
                    sd_q  <= 1'b0;
                end
                default: ;
            endcase
            if (step == STEP_BAD) flag_q <= 1'b1;
            else if (flag_clr)    flag_q <= 1'b0;
        end
    end

    assign position     = raw_q + {{(CNT_W-1){1'b0}}, hold_high};
    assign illegal_flag = flag_q;
    assign step_valid   = sv_q;
    assign step_dir     = sd_q;

endmodule

// File: rtl/qdec_tracker_chk.sv
module qdec_tracker_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             arst,
    input logic             srst,
    input logic             hyst_en,
    input logic             flag_clr,
    input logic [1:0]       cur_ab,
    input logic [1:0]       prev_ab,
    input logic [CNT_W-1:0] raw,
    input logic [CNT_W-1:0] position,
    input logic             illegal_flag,
    input logic             step_valid,
    input logic             step_dir
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_BAD_NO_MOVE: assert property (@(posedge clk) disable iff (arst)
        (!srst && ((cur_ab ^ prev_ab) == 2'b11))
        |=> (illegal_flag && !step_valid && raw == $past(raw))); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (arst)
        (illegal_flag && !srst && !flag_clr) |=> illegal_flag); // R4

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (arst)
        !srst |=> (raw == $past(raw) || raw == $past(raw) + ONE
                   || raw == $past(raw) - ONE)); // R2

    AST_STROBE_UP: assert property (@(posedge clk) disable iff (arst)
        (step_valid && step_dir) |-> raw == $past(raw) + ONE); // R6

    AST_STROBE_DOWN: assert property (@(posedge clk) disable iff (arst)
        (step_valid && !step_dir) |-> raw == $past(raw) - ONE); // R6

    AST_HYST_BAND: assert property (@(posedge clk) disable iff (arst)
        (position == raw) || (position == raw + ONE)); // R7

    AST_NOHYST_EQUAL: assert property (@(posedge clk) disable iff (arst)
        !hyst_en |=> position == raw); // R8

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (arst)
        srst |=> (raw == '0 && position == '0 && !illegal_flag)); // R9

endmodule

bind qdec_tracker qdec_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .arst         (arst),
    .srst         (srst),
    .hyst_en      (hyst_en),
    .flag_clr     (flag_clr),
    .cur_ab       (smp_ab),
    .prev_ab      (prev_ab),
    .raw          (raw_q),
    .position     (position),
    .illegal_flag (illegal_flag),
    .step_valid   (step_valid),
    .step_dir     (step_dir)
);

// File: tb/sim_qdec_tracker.sv
`timescale 1ns/1ps
module sim_qdec_tracker;

    localparam int CW = 4;

    logic clk = 1'b0;
    logic arst, srst, hyst_en, flag_clr, pa, pb;
    logic [CW-1:0] pos;
    logic ill, sv, sd;
    int errs = 0;
    int checks = 0;
    int idx = 0;

    always #5 clk = ~clk;

    qdec_tracker #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .arst(arst), .srst(srst), .hyst_en(hyst_en),
        .flag_clr(flag_clr), .phase_a(pa), .phase_b(pb),
        .position(pos), .illegal_flag(ill), .step_valid(sv), .step_dir(sd)
    );

    function automatic logic [1:0] ab_of(int i);
        case (i)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_idx(int ni);
        @(negedge clk);
        idx = ni;
        {pa, pb} = ab_of(ni);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic move(int d, int exp_pos, string req);
        drive_idx((idx + d + 4) % 4);
        check(req, "position", int'(pos), exp_pos);
        check(req, "step_valid", int'(sv), 1);
        check(req, "step_dir", int'(sd), (d > 0) ? 1 : 0);
    endtask

    task automatic pulse_srst();
        @(negedge clk); srst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); srst = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", "position after arst", int'(pos), 0);
        check("R10", "flag after arst", int'(ill), 0);
        check("R10", "strobe after arst", int'(sv), 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        idx = 1; {pa, pb} = ab_of(1);
        repeat (2) @(posedge clk); #1;
        check("R1", "position before third edge", int'(pos), 0);
        @(posedge clk); #1;
        check("R1", "position after third edge", int'(pos), 1);
        check("R6", "strobe with update", int'(sv), 1);
        check("R6", "direction up", int'(sd), 1);
        @(posedge clk); #1;
        check("R6", "strobe one cycle", int'(sv), 0);
    endtask

    task automatic t_forward_reverse();
        move(1, 2, "R2");
        move(1, 3, "R2");
        move(1, 4, "R2");   // full line: four counts
        move(-1, 3, "R2");
        move(-1, 2, "R2");
    endtask

    task automatic t_bounce();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            idx = (i % 2 == 0) ? 3 : 2;
            {pa, pb} = ab_of(idx);
        end
        repeat (4) @(posedge clk); #1;
        check("R5", "net position after bounce", int'(pos), 3);
        check("R5", "no flag from bounce", int'(ill), 0);
    endtask

    task automatic t_illegal();
        drive_idx(1);   // 01 -> 10
        check("R3", "position held", int'(pos), 3);
        check("R3", "flag raised", int'(ill), 1);
        check("R3", "no strobe", int'(sv), 0);
    endtask

    task automatic t_flag();
        repeat (5) @(posedge clk); #1;
        check("R4", "flag sticky", int'(ill), 1);
        pulse_clr();
        check("R4", "flag cleared", int'(ill), 0);
        @(negedge clk);
        idx = 3; {pa, pb} = ab_of(3);
        repeat (2) @(posedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(posedge clk); #1;
        check("R4", "set wins over clear", int'(ill), 1);
        @(negedge clk); flag_clr = 1'b0;
        pulse_clr();
        check("R4", "flag cleared again", int'(ill), 0);
        check("R3", "position after second illegal", int'(pos), 3);
    endtask

    task automatic t_srst();
        drive_idx(1);
        check("R3", "flag before srst", int'(ill), 1);
        pulse_srst();
        check("R9", "position zero", int'(pos), 0);
        check("R9", "flag cleared", int'(ill), 0);
        repeat (3) @(posedge clk); #1;
        check("R9", "no step from history", int'(pos), 0);
        check("R9", "no flag from history", int'(ill), 0);
        move(1, 1, "R9");
    endtask

    task automatic t_wrap();
        pulse_srst();
        for (int k = 0; k < 16; k++) begin
            drive_idx((idx + 1) % 4);
            check("R11", "forward count", int'(pos), (k + 1) % 16);
        end
        move(-1, 15, "R11");
    endtask

    task automatic t_hyst();
        @(negedge clk); hyst_en = 1'b1;
        pulse_srst();
        move(1, 1, "R7");
        move(1, 2, "R7");
        move(-1, 2, "R7");
        move(1, 2, "R7");
        move(-1, 2, "R7");
        move(-1, 1, "R7");
        move(1, 1, "R7");
        move(-1, 1, "R7");  // held high, internal count 0
        @(negedge clk); hyst_en = 1'b0;
        @(posedge clk); #1;
        check("R8", "drop to internal count", int'(pos), 0);
        move(1, 1, "R8");
        move(-1, 0, "R8");
    endtask

    task automatic t_arst();
        drive_idx(2);
        @(negedge clk); #2;
        arst = 1'b1; #1;
        check("R10", "async position clear", int'(pos), 0);
        check("R10", "async strobe clear", int'(sv), 0);
        pa = 1'b0; pb = 1'b0; idx = 0;
        @(negedge clk); arst = 1'b0;
        repeat (4) @(posedge clk); #1;
        check("R10", "position after release", int'(pos), 0);
        check("R10", "flag after release", int'(ill), 0);
    endtask

    initial begin
        arst = 1'b1; srst = 1'b0; hyst_en = 1'b0; flag_clr = 1'b0;
        pa = 1'b0; pb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); arst = 1'b0;
        #1;
        t_reset();
        t_latency();
        t_forward_reverse();
        t_bounce();
        t_illegal();
        t_flag();
        t_srst();
        t_wrap();
        t_hyst();
        t_arst();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule